// File: doc/BRIEF.md
# Read-Sequence Command Unlock

This block sits beside an asynchronous SRAM port and watches the bus cycles for a fixed run of six reads that unlocks a nonvolatile command. The first five reads form a common prefix. The sixth read selects the command: a save of the array to nonvolatile storage, or a reload of the array from it. Because the unlock uses only ordinary read cycles, the memory interface stays that of a plain SRAM. The block gives the store/recall controller a one-clock request pulse. It also drives a small step indicator for debug.

The chip-enable strobe (`ce_n`, active low) is brought into the `clk` domain through a synchronizer chain. Each enable pulse is one candidate step. The address is captured when the synchronized falling edge is seen. A pulse counts as a write if write-enable is low at the falling edge or at any clock during the pulse. The step is judged when the synchronized rising edge arrives.

The state machine has these states:
- `ST_IDLE`: no step matched.
- `ST_S1` to `ST_S5`: that many steps matched.
- `ST_ARMED`: a command was issued and the block waits for the controller.
- `ST_LOCK`: the controller reports busy.

It has these transitions:
- **advance**: the read matches the next key.
- **issue**: from `ST_S5` to `ST_ARMED`, on the store key or the recall key.
- **restart**: a mismatching read of address 0 goes to `ST_S1`.
- **abort**: any other mismatch, or any write, goes to `ST_IDLE`.
- **busy**: from any state to `ST_LOCK` while `nv_busy` is high.
- **release**: from `ST_LOCK` to `ST_IDLE` when `nv_busy` falls.

The block has no output-enable input, so that pin cannot affect recognition.

Top module: `nv_unlock_detector`

## Requirements
- R1: While reset is asserted and right after it, `step` is 0 and neither request is high.
- R2: `step` is 0 in idle and k after k consecutive matching reads, for k from 1 to 5. The reads must be, in order, 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0. `step` reads 6 while a command is pending or the controller is busy.
- R3: A read of 0x0F0F after the five-read prefix gives `store_req` high for exactly one clock.
- R4: A read of 0x0F0E after the five-read prefix gives `recall_req` high for exactly one clock. Both requests are never high together.
- R5: A read that does not match the expected step aborts the sequence to step 0. So does any pulse in which `we_n` was low at any sampled clock. A write never starts a new sequence.
- R6: When an aborting read is itself a read of 0x0000, it counts as step 1 of a new sequence.
- R7: A sixth read of 0x139C after the prefix issues no request and returns to step 0.
- R8: A chip-enable low pulse that is seen by a single clock still counts as a step. A step is judged at the third clock edge after `ce_n` returns high. Any request appears after that edge.
- R9: After a request, all enable pulses are ignored and `step` stays 6 until `nv_busy` has been high. When `nv_busy` then falls, the next clock returns `step` to 0.
- R10: `nv_busy` high at any point discards any partial sequence and forces `step` to 6 on the next clock.
- R11: Two pulses in a row to the same address count as a mismatch at the second pulse. An example is enable noise repeating the read of 0x1555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | SRAM chip enable, active low, asynchronous to clk |
| we_n | input | 1 | SRAM write enable, active low |
| addr | input | 13 | SRAM address |
| nv_busy | input | 1 | Controller reports a nonvolatile cycle in progress |
| store_req | output | 1 | One-clock request to save the array |
| recall_req | output | 1 | One-clock request to reload the array |
| step | output | 3 | Debug step indicator (0 idle, 1 to 5 matched, 6 locked) |

## Verification
The bench targets these corner cases, each with the fault it would expose:
- **Restart on 0x0000.** It re-reads 0x0000 in mid-sequence. A design that only went back to idle would then miss the store that follows.
- **Reserved key.** It ends the prefix with the test address 0x139C. A design that decoded only some address bits would issue a request.
- **Write in mid-pulse.** It pulls write-enable low partway through an enable pulse. A design that looked at write-enable only at the edge would treat that pulse as a read.
- **Minimal pulse.** It runs a whole sequence with one-clock enable pulses. This shows whether a short strobe is lost in the synchronizer.
- **Lockout.** It sends enable pulses while a command is pending and while the controller is busy. A design without the lockout would move `step` away from 6 or start counting early.

// File: rtl/nvu_pkg.sv
package nvu_pkg;

    localparam int ADDR_W = 13;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_S1    = 3'd1,
        ST_S2    = 3'd2,
        ST_S3    = 3'd3,
        ST_S4    = 3'd4,
        ST_S5    = 3'd5,
        ST_ARMED = 3'd6,
        ST_LOCK  = 3'd7
    } seq_state_e;

    localparam addr_t STORE_KEY  = 13'h0F0F;
    localparam addr_t RECALL_KEY = 13'h0F0E;

    // Expected address for the read that follows 'idx' matched steps.
    function automatic addr_t prefix_key(input logic [2:0] idx);
        addr_t key;
        case (idx)
            3'd0:    key = 13'h0000;
            3'd1:    key = 13'h1555;
            3'd2:    key = 13'h0AAA;
            3'd3:    key = 13'h1FFF;
            3'd4:    key = 13'h10F0;
            default: key = 13'h0000;
        endcase
        return key;
    endfunction

endpackage

// File: rtl/nvu_ce_sync.sv
module nvu_ce_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_raw,
    output logic ce_fall,
    output logic ce_rise
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              ce_last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= ce_n_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_last <= 1'b1;
        else        ce_last <= chain[LAST];
    end

    assign ce_fall = ce_last & ~chain[LAST];
    assign ce_rise = ~ce_last & chain[LAST];

    // R8
    fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_fall |=> !ce_fall);

endmodule

// File: rtl/nvu_step_capture.sv
module nvu_step_capture
    import nvu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce_fall,
    input  logic  ce_rise,
    input  logic  lock,
    input  logic  we_n,
    input  addr_t addr,
    output logic  step_evt,
    output addr_t evt_addr,
    output logic  evt_wr
);

    logic  valid;
    addr_t cap_addr;
    logic  cap_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            cap_addr <= '0;
            cap_wr   <= 1'b0;
        end else if (ce_fall && !lock) begin
            valid    <= 1'b1;
            cap_addr <= addr;
            cap_wr   <= ~we_n;
        end else if (ce_rise) begin
            valid    <= 1'b0;
        end else if (valid && !we_n) begin
            cap_wr   <= 1'b1;
        end
    end

    assign step_evt = ce_rise & valid;
    assign evt_addr = cap_addr;
    assign evt_wr   = cap_wr;

    // R9
    no_open_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> !$past(lock));

    // R5
    write_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cap_wr && !ce_rise && !ce_fall) |=> cap_wr);

endmodule

// File: rtl/nvu_seq_fsm.sv
module nvu_seq_fsm
    import nvu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_evt,
    input  addr_t      evt_addr,
    input  logic       evt_wr,
    input  logic       nv_busy,
    output logic       store_req,
    output logic       recall_req,
    output logic       locked,
    output logic [2:0] step
);

    seq_state_e state, nxt;
    seq_state_e restart;
    logic       issue_store, issue_recall;

    assign restart = (evt_addr == prefix_key(3'd0)) ? ST_S1 : ST_IDLE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt          = state;
        issue_store  = 1'b0;
        issue_recall = 1'b0;
        if (nv_busy) begin
            nxt = ST_LOCK;
        end else begin
            unique case (state)
                ST_ARMED: nxt = ST_ARMED;
                ST_LOCK:  nxt = ST_IDLE;
                default: begin
                    if (step_evt) begin
                        if (evt_wr) begin
                            nxt = ST_IDLE;
                        end else if (state == ST_S5) begin
                            if (evt_addr == STORE_KEY) begin
                                nxt         = ST_ARMED;
                                issue_store = 1'b1;
                            end else if (evt_addr == RECALL_KEY) begin
                                nxt          = ST_ARMED;
                                issue_recall = 1'b1;
                            end else begin
                                nxt = restart;
                            end
                        end else if (evt_addr == prefix_key(state)) begin
                            nxt = seq_state_e'(state + 3'd1);
                        end else begin
                            nxt = restart;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            store_req  <= issue_store;
            recall_req <= issue_recall;
        end
    end

    assign locked = (state == ST_ARMED) || (state == ST_LOCK);
    assign step   = (state == ST_LOCK) ? 3'd6 : state;

    // R3
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    // R4
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));

    // R7
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> ($past(state) == ST_S5));

    // R10
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |=> (state == ST_LOCK));

    // R9
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !nv_busy) |=> (state == ST_ARMED));

endmodule

// File: rtl/nv_unlock_detector.sv
module nv_unlock_detector
    import nvu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              nv_busy,
    output logic              store_req,
    output logic              recall_req,
    output logic [2:0]        step
);

    logic  ce_fall, ce_rise;
    logic  step_evt, evt_wr, locked;
    addr_t evt_addr;

    nvu_ce_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_raw (ce_n),
        .ce_fall  (ce_fall),
        .ce_rise  (ce_rise)
    );

    nvu_step_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_fall  (ce_fall),
        .ce_rise  (ce_rise),
        .lock     (locked | nv_busy),
        .we_n     (we_n),
        .addr     (addr),
        .step_evt (step_evt),
        .evt_addr (evt_addr),
        .evt_wr   (evt_wr)
    );

    nvu_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_evt   (step_evt),
        .evt_addr   (evt_addr),
        .evt_wr     (evt_wr),
        .nv_busy    (nv_busy),
        .store_req  (store_req),
        .recall_req (recall_req),
        .locked     (locked),
        .step       (step)
    );

endmodule

// File: tb/nv_unlock_detector_test.sv
module nv_unlock_detector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        nv_busy = 1'b0;
    logic [12:0] addr = '0;
    logic        store_req, recall_req;
    logic [2:0]  step;

    always #4 clk = ~clk;

    nv_unlock_detector uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .nv_busy(nv_busy), .store_req(store_req), .recall_req(recall_req), .step(step)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int n_store = 0;
    int n_recall = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising clock edge.
    int hist[$];
    int mst = 0;
    bit mvalid = 0;
    bit mwr = 0;
    int maddr = 0;
    bit e_store = 0;
    bit e_recall = 0;

    function automatic int pref(input int k);
        case (k)
            0: return 'h0000;
            1: return 'h1555;
            2: return 'h0AAA;
            3: return 'h1FFF;
            default: return 'h10F0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{1, 1, 1, 1};
            mst = 0; mvalid = 0; mwr = 0; maddr = 0; e_store = 0; e_recall = 0;
        end else begin
            int h2, h3, nst;
            bit fv, rv, lk, ev;
            hist.push_back(int'(ce_n));
            if (hist.size() > 8) void'(hist.pop_front());
            h2 = hist[hist.size()-3];
            h3 = hist[hist.size()-4];
            fv = (h3 == 1 && h2 == 0);
            rv = (h3 == 0 && h2 == 1);
            lk = (mst >= 6) || nv_busy;
            ev = rv && mvalid;
            e_store = 0; e_recall = 0; nst = mst;
            if (nv_busy) nst = 7;
            else if (mst == 6) nst = 6;
            else if (mst == 7) nst = 0;
            else if (ev) begin
                if (mwr) nst = 0;
                else if (mst == 5) begin
                    if (maddr == 'h0F0F) begin nst = 6; e_store = 1; end
                    else if (maddr == 'h0F0E) begin nst = 6; e_recall = 1; end
                    else nst = (maddr == 0) ? 1 : 0;
                end else if (maddr == pref(mst)) nst = mst + 1;
                else nst = (maddr == 0) ? 1 : 0;
            end
            if (fv && !lk) begin
                mvalid = 1; maddr = int'(addr); mwr = !we_n;
            end else if (rv) begin
                mvalid = 0;
            end else if (mvalid && !we_n) begin
                mwr = 1;
            end
            mst = nst;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 step per-cycle", int'(step), (mst >= 6) ? 6 : mst);
            chk("R3 store_req per-cycle", int'(store_req), int'(e_store));
            chk("R4 recall_req per-cycle", int'(recall_req), int'(e_recall));
        end
        if (store_req)  n_store++;
        if (recall_req) n_recall++;
    end

    task automatic rd(input logic [12:0] a, input int low = 5);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0;
        repeat (low) @(negedge clk);
        ce_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic wr(input logic [12:0] a);
        @(negedge clk);
        addr = a; we_n = 1'b0; ce_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic wr_mid(input logic [12:0] a);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic prefix(input int low = 5);
        rd(13'h0000, low); rd(13'h1555, low); rd(13'h0AAA, low);
        rd(13'h1FFF, low); rd(13'h10F0, low);
    endtask

    task automatic finish_cmd();
        @(negedge clk); nv_busy = 1'b1;
        repeat (4) @(negedge clk);
        nv_busy = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 step in reset", int'(step), 0);
        chk("R1 store_req in reset", int'(store_req), 0);
        chk("R1 recall_req in reset", int'(recall_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 step after reset", int'(step), 0);

        // R2, R3: full store sequence
        rd(13'h0000);
        chk("R2 step after first read", int'(step), 1);
        rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0);
        chk("R2 step after prefix", int'(step), 5);
        rd(13'h0F0F);
        chk("R3 store pulses", n_store, 1);
        chk("R3 no recall on store key", n_recall, 0);
        chk("R2 step locked", int'(step), 6);

        // R9: pulses ignored while armed and busy
        rd(13'h0000);
        chk("R9 step while armed", int'(step), 6);
        @(negedge clk); nv_busy = 1'b1;
        rd(13'h0000);
        chk("R9 step while busy", int'(step), 6);
        nv_busy = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 step after busy falls", int'(step), 0);

        // R4: recall sequence
        prefix();
        rd(13'h0F0E);
        chk("R4 recall pulses", n_recall, 1);
        chk("R4 store count unchanged", n_store, 1);
        finish_cmd();

        // R5: mismatching read, write in pulse, write mid-pulse
        rd(13'h0000); rd(13'h1555); rd(13'h1FFF);
        chk("R5 step after wrong read", int'(step), 0);
        rd(13'h0000); rd(13'h1555); wr(13'h0AAA);
        chk("R5 step after write", int'(step), 0);
        rd(13'h0000); wr_mid(13'h1555);
        chk("R5 step after mid-pulse write", int'(step), 0);
        wr(13'h0000);
        chk("R5 write to 0 does not start", int'(step), 0);

        // R6: restart on 0x0000
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h0000);
        chk("R6 step after restart", int'(step), 1);
        rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        chk("R6 store after restart", n_store, 2);
        finish_cmd();

        // R7: reserved test key
        prefix();
        rd(13'h139C);
        chk("R7 step after test key", int'(step), 0);
        chk("R7 no store on test key", n_store, 2);
        chk("R7 no recall on test key", n_recall, 1);

        // R8: one-clock enable pulses
        prefix(1);
        chk("R8 step after short prefix", int'(step), 5);
        rd(13'h0F0F, 1);
        chk("R8 store from short pulses", n_store, 3);
        finish_cmd();

        // R11: repeated pulse to same address
        rd(13'h0000); rd(13'h1555); rd(13'h1555);
        chk("R11 step after repeated address", int'(step), 0);

        // R10: busy mid-sequence
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA);
        @(negedge clk); nv_busy = 1'b1;
        @(negedge clk);
        chk("R10 step when busy", int'(step), 6);
        nv_busy = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 step after busy", int'(step), 0);
        rd(13'h1FFF);
        chk("R10 partial sequence dropped", int'(step), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule